// File: doc/BRIEF.md
# Keyed Clock-Control Register Bank

This block is the software-visible register bank of a clock manager. It holds one control word and one analog word for each PLL and one divider word for each PLL output channel. It decodes a byte-addressed 32-bit access port and tells the clock generation logic which parts must re-evaluate their settings. Every write carries an 8-bit key in its upper byte. A write whose key is wrong is discarded as a whole: nothing is stored and no update strobe fires. Instead, a one-cycle error pulse is raised. An accepted write is stored with its key byte forced to zero.

A read-only lock status word is not stored. It is built on the fly from each PLL's power-down bit and analog-reset bit, so it always reflects the current contents of the bank. After an accepted write, one update strobe per affected sub-block rises for one cycle. A write to a PLL control word touches that PLL and every channel it feeds. A write to a PLL analog word touches only the PLL. A write to a channel word touches only that channel. The window is 0x2000 bytes, and only word-aligned accesses are decoded.

Top module: `clkreg_bank`

## Requirements
- R1: A write is dropped entirely, with no storage change and no strobe, unless wdata[31:24] equals 0x5A.
- R2: An accepted write stores wdata with bits 31:24 cleared to zero.
- R3: pw_err is high for exactly the one cycle following a write whose key byte is not 0x5A, and is low otherwise.
- R4: Byte map: PLL p control word at 0x100+4p, PLL p analog word at 0x200+4p, channel c word at 0x300+4c. Channel c is fed by PLL c/2. rdata shows the addressed word in the cycle after rd_en.
- R5: An access whose address has bits 1:0 nonzero, or which hits no mapped word, has no effect when written and reads as zero.
- R6: The word at 0x080 reads bit 8+p as 1 exactly when bit 16 (power-down) of PLL p's analog word and bit 8 (analog reset) of its control word are both 0. All other bits read zero. Writes to 0x080 are ignored and raise no error.
- R7: After reset, control words read 0x00000100, analog words 0x00010000, channel words 0x00000100, the lock word 0, and all strobes and pw_err are low.
- R8: An accepted write to PLL p's control word pulses pll_upd[p] and chan_upd for each channel fed by PLL p, one cycle after the write.
- R9: An accepted write to PLL p's analog word pulses only pll_upd[p]. An accepted write to channel c's word pulses only chan_upd[c].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | 13 | Byte address within the window |
| wdata | input | 32 | Write data, key in bits 31:24 |
| rdata | output | 32 | Registered read data |
| pll_upd | output | 5 | Per-PLL update strobes |
| chan_upd | output | 10 | Per-channel update strobes |
| pw_err | output | 1 | Rejected-write pulse |

## Verification
The write path is driven with correct keys, wrong keys (including one differing by a single bit), misaligned addresses, unmapped addresses and the read-only lock address. The strobe, error and read-back results separate true acceptance from silent drops. The three register kinds are each written so that the strobe fan-out tells a control-word write (PLL plus its channels) from an analog or channel write. The lock word is read while power-down and analog-reset are toggled independently per PLL, which shows that both conditions are required and that the flags sit at their own bit positions.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;

    localparam int          DATA_W  = 32;
    localparam int          KEY_LSB = 24;
    localparam logic [7:0]  WR_KEY  = 8'h5A;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_LOCK,
        RK_PLLCM,
        RK_PLLANA,
        RK_CHAN
    } reg_kind_e;

    function automatic logic key_ok(input logic [DATA_W-1:0] d);
        return d[DATA_W-1:KEY_LSB] == WR_KEY;
    endfunction

    function automatic logic [DATA_W-1:0] strip_key(input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r;
        r = d;
        r[DATA_W-1:KEY_LSB] = '0;
        return r;
    endfunction

endpackage

// File: rtl/clkreg_decode.sv
module clkreg_decode
    import clkreg_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int NUM_PLL   = 5,
    parameter int NUM_CHAN  = 10,
    parameter int LOCK_BYTE = 'h080,
    parameter int CM_BYTE   = 'h100,
    parameter int ANA_BYTE  = 'h200,
    parameter int CHAN_BYTE = 'h300,
    parameter int SEL_W     = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [SEL_W-1:0]  sel
);

    localparam int WW = ADDR_W - 2;
    localparam logic [WW-1:0] LOCK_W  = WW'(LOCK_BYTE / 4);
    localparam logic [WW-1:0] CM_W    = WW'(CM_BYTE / 4);
    localparam logic [WW-1:0] CM_END  = WW'(CM_BYTE / 4 + NUM_PLL);
    localparam logic [WW-1:0] ANA_W   = WW'(ANA_BYTE / 4);
    localparam logic [WW-1:0] ANA_END = WW'(ANA_BYTE / 4 + NUM_PLL);
    localparam logic [WW-1:0] CH_W    = WW'(CHAN_BYTE / 4);
    localparam logic [WW-1:0] CH_END  = WW'(CHAN_BYTE / 4 + NUM_CHAN);

    logic [WW-1:0] word;
    logic [WW-1:0] off;

    assign word = addr[ADDR_W-1:2];

    always_comb begin
        kind = RK_NONE;
        off  = '0;
        if (addr[1:0] == 2'b00) begin
            if (word == LOCK_W) begin
                kind = RK_LOCK;
            end else if (word >= CM_W && word < CM_END) begin
                kind = RK_PLLCM;
                off  = word - CM_W;
            end else if (word >= ANA_W && word < ANA_END) begin
                kind = RK_PLLANA;
                off  = word - ANA_W;
            end else if (word >= CH_W && word < CH_END) begin
                kind = RK_CHAN;
                off  = word - CH_W;
            end
        end
    end

    assign sel = off[SEL_W-1:0];

endmodule

// File: rtl/clkreg_lock.sv
module clkreg_lock #(
    parameter int NUM_PLL    = 5,
    parameter int PWRDN_BIT  = 16,
    parameter int ANARST_BIT = 8,
    parameter int LOCK_LSB   = 8
) (
    input  logic [NUM_PLL-1:0][31:0] cm_words,
    input  logic [NUM_PLL-1:0][31:0] ana_words,
    output logic [31:0]              lock_word
);

    logic [NUM_PLL-1:0] locked;

    for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
        assign locked[p] = !ana_words[p][PWRDN_BIT] && !cm_words[p][ANARST_BIT];
    end

    always_comb begin
        lock_word = '0;
        lock_word[LOCK_LSB +: NUM_PLL] = locked;
    end

endmodule

// File: rtl/clkreg_strobe.sv
module clkreg_strobe
    import clkreg_pkg::*;
#(
    parameter int NUM_PLL    = 5,
    parameter int CH_PER_PLL = 2,
    parameter int SEL_W      = 4,
    localparam int NUM_CHAN  = NUM_PLL * CH_PER_PLL
) (
    input  logic                accept,
    input  reg_kind_e           kind,
    input  logic [SEL_W-1:0]    sel,
    output logic [NUM_PLL-1:0]  pll_hit,
    output logic [NUM_CHAN-1:0] chan_hit
);

    for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
        assign pll_hit[p] = accept && (sel == SEL_W'(p))
                         && (kind == RK_PLLCM || kind == RK_PLLANA);
    end

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        localparam int PARENT = c / CH_PER_PLL;
        assign chan_hit[c] = accept
            && ((kind == RK_CHAN  && sel == SEL_W'(c))
             || (kind == RK_PLLCM && sel == SEL_W'(PARENT)));
    end

endmodule

// File: rtl/clkreg_bank.sv
module clkreg_bank
    import clkreg_pkg::*;
#(
    parameter int          ADDR_W     = 13,
    parameter int          NUM_PLL    = 5,
    parameter int          CH_PER_PLL = 2,
    parameter logic [31:0] CM_RST     = 32'h0000_0100,
    parameter logic [31:0] ANA_RST    = 32'h0001_0000,
    parameter logic [31:0] CHAN_RST   = 32'h0000_0100,
    localparam int         NUM_CHAN   = NUM_PLL * CH_PER_PLL
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    output logic [NUM_PLL-1:0]  pll_upd,
    output logic [NUM_CHAN-1:0] chan_upd,
    output logic                pw_err
);

    localparam int SEL_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;

    typedef struct packed {
        logic [NUM_PLL-1:0][31:0]  cm;
        logic [NUM_PLL-1:0][31:0]  ana;
        logic [NUM_CHAN-1:0][31:0] ch;
        logic [31:0]               rdata;
        logic [NUM_PLL-1:0]        pll_upd;
        logic [NUM_CHAN-1:0]       chan_upd;
        logic                      err;
    } state_t;

    state_t s_q, s_d, s_rst;

    reg_kind_e           kind;
    logic [SEL_W-1:0]    sel;
    logic                accept;
    logic [NUM_PLL-1:0]  pll_hit;
    logic [NUM_CHAN-1:0] chan_hit;
    logic [31:0]         lock_word;
    logic [31:0]         wval;

    clkreg_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_PLL  (NUM_PLL),
        .NUM_CHAN (NUM_CHAN),
        .SEL_W    (SEL_W)
    ) u_decode (
        .addr (addr),
        .kind (kind),
        .sel  (sel)
    );

    clkreg_lock #(
        .NUM_PLL (NUM_PLL)
    ) u_lock (
        .cm_words  (s_q.cm),
        .ana_words (s_q.ana),
        .lock_word (lock_word)
    );

    assign accept = wr_en && key_ok(wdata);
    assign wval   = strip_key(wdata);

    clkreg_strobe #(
        .NUM_PLL    (NUM_PLL),
        .CH_PER_PLL (CH_PER_PLL),
        .SEL_W      (SEL_W)
    ) u_strobe (
        .accept   (accept),
        .kind     (kind),
        .sel      (sel),
        .pll_hit  (pll_hit),
        .chan_hit (chan_hit)
    );

    always_comb begin
        s_rst = '0;
        for (int p = 0; p < NUM_PLL; p++) begin
            s_rst.cm[p]  = CM_RST;
            s_rst.ana[p] = ANA_RST;
        end
        for (int c = 0; c < NUM_CHAN; c++) begin
            s_rst.ch[c] = CHAN_RST;
        end
    end

    always_comb begin
        s_d          = s_q;
        s_d.pll_upd  = pll_hit;
        s_d.chan_upd = chan_hit;
        s_d.err      = wr_en && !key_ok(wdata);

        if (accept) begin
            for (int p = 0; p < NUM_PLL; p++) begin
                if (sel == SEL_W'(p) && kind == RK_PLLCM)  s_d.cm[p]  = wval;
                if (sel == SEL_W'(p) && kind == RK_PLLANA) s_d.ana[p] = wval;
            end
            for (int c = 0; c < NUM_CHAN; c++) begin
                if (sel == SEL_W'(c) && kind == RK_CHAN) s_d.ch[c] = wval;
            end
        end

        if (rd_en) begin
            s_d.rdata = '0;
            if (kind == RK_LOCK) s_d.rdata = lock_word;
            for (int p = 0; p < NUM_PLL; p++) begin
                if (sel == SEL_W'(p) && kind == RK_PLLCM)  s_d.rdata = s_q.cm[p];
                if (sel == SEL_W'(p) && kind == RK_PLLANA) s_d.rdata = s_q.ana[p];
            end
            for (int c = 0; c < NUM_CHAN; c++) begin
                if (sel == SEL_W'(c) && kind == RK_CHAN) s_d.rdata = s_q.ch[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= s_rst;
        else        s_q <= s_d;
    end

    assign rdata    = s_q.rdata;
    assign pll_upd  = s_q.pll_upd;
    assign chan_upd = s_q.chan_upd;
    assign pw_err   = s_q.err;

endmodule

// File: rtl/clkreg_bank_chk.sv
module clkreg_bank_chk #(
    parameter int NUM_PLL  = 5,
    parameter int NUM_CHAN = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [31:0]         wdata,
    input logic [NUM_PLL-1:0]  pll_upd,
    input logic [NUM_CHAN-1:0] chan_upd,
    input logic                pw_err,
    input logic [31:0]         lock_word
);

    localparam logic [31:0] LOCK_MASK = ((32'd1 << NUM_PLL) - 32'd1) << 8;

    // R3: wrong key yields the error pulse next cycle
    a_r3_err_on_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wdata[31:24] != 8'h5A |=> pw_err);

    // R3: no error unless a wrongly keyed write came before
    a_r3_err_only_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wdata[31:24] != 8'h5A) |=> !pw_err);

    // R1: a dropped write fires no strobe
    a_r1_drop_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wdata[31:24] != 8'h5A |=> (pll_upd == '0 && chan_upd == '0));

    // R9: at most one PLL strobed per write
    a_r9_one_pll: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pll_upd));

    // R9: without a PLL strobe at most one channel strobed
    a_r9_one_chan: assert property (@(posedge clk) disable iff (!rst_n)
        pll_upd == '0 |-> $onehot0(chan_upd));

    // R8: strobes only follow a write
    a_r8_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (pll_upd == '0 && chan_upd == '0));

    // R6: lock word changes only after a write
    a_r6_lock_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(lock_word));

    // R6: only the lock flag bits can be set
    a_r6_lock_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_word & ~LOCK_MASK) == 32'd0);

endmodule

bind clkreg_bank clkreg_bank_chk #(
    .NUM_PLL  (NUM_PLL),
    .NUM_CHAN (NUM_CHAN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .pll_upd   (pll_upd),
    .chan_upd  (chan_upd),
    .pw_err    (pw_err),
    .lock_word (lock_word)
);

// File: tb/clkreg_bank_test.sv
module clkreg_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [12:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [4:0]  pll_upd;
    logic [9:0]  chan_upd;
    logic        pw_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    clkreg_bank uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .pll_upd  (pll_upd),
        .chan_upd (chan_upd),
        .pw_err   (pw_err)
    );

    typedef struct packed {
        logic [12:0] a;
        logic [31:0] d;
        logic [4:0]  p;
        logic [9:0]  c;
        logic        e;
        logic [31:0] r;
    } vec_t;

    // R8 R9 R1 R2 R5 R6 exercised by the table
    localparam vec_t TBL [10] = '{
        '{13'h100, 32'h5A00_0000, 5'h01, 10'h003, 1'b0, 32'h0000_0000},
        '{13'h200, 32'h5A00_0000, 5'h01, 10'h000, 1'b0, 32'h0000_0000},
        '{13'h30C, 32'h5A00_0025, 5'h00, 10'h008, 1'b0, 32'h0000_0025},
        '{13'h108, 32'h3300_0000, 5'h00, 10'h000, 1'b1, 32'h0000_0100},
        '{13'h210, 32'h5AFF_1234, 5'h10, 10'h000, 1'b0, 32'h00FF_1234},
        '{13'h110, 32'h5A00_0000, 5'h10, 10'h300, 1'b0, 32'h0000_0000},
        '{13'h324, 32'hA500_0077, 5'h00, 10'h000, 1'b1, 32'h0000_0100},
        '{13'h080, 32'h5A00_FFFF, 5'h00, 10'h000, 1'b0, 32'h0000_0100},
        '{13'h1FFC,32'h5A00_0001, 5'h00, 10'h000, 1'b0, 32'h0000_0000},
        '{13'h102, 32'h5A00_0100, 5'h00, 10'h000, 1'b0, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [12:0] a, input logic [31:0] d,
                            input logic [4:0] ep, input logic [9:0] ec,
                            input logic ee, input string req);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check({req, " pll_upd"},  32'(pll_upd),  32'(ep));
        check({req, " chan_upd"}, 32'(chan_upd), 32'(ec));
        check({req, " pw_err"},   32'(pw_err),   32'(ee));
        @(negedge clk);
        check({req, " pulse width"}, 32'({pw_err, pll_upd, chan_upd}), 32'd0);
    endtask

    task automatic do_read(input logic [12:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check({req, " rdata"}, rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7 reset state
        @(negedge clk);
        check("R7 strobes idle", 32'({pw_err, pll_upd, chan_upd}), 32'd0);
        do_read(13'h080, 32'h0000_0000, "R7 lock");
        do_read(13'h108, 32'h0000_0100, "R7 control word");
        do_read(13'h208, 32'h0001_0000, "R7 analog word");
        do_read(13'h31C, 32'h0000_0100, "R7 channel word");

        for (int i = 0; i < 10; i++) begin
            do_write(TBL[i].a, TBL[i].d, TBL[i].p, TBL[i].c, TBL[i].e, "R4 table");
            do_read(TBL[i].a, TBL[i].r, "R4 table readback");
        end

        // R6 clearing power-down on PLL4 while its analog reset is clear
        do_write(13'h210, 32'h5A00_1234, 5'h10, 10'h000, 1'b0, "R9 analog");
        do_read(13'h080, 32'h0000_1100, "R6 lock two plls");
        // R6 analog reset alone unlocks PLL4
        do_write(13'h110, 32'h5A00_0100, 5'h10, 10'h300, 1'b0, "R8 control");
        do_read(13'h080, 32'h0000_0100, "R6 lock after anarst");
        // R1 key off by one bit
        do_write(13'h100, 32'h5B00_0100, 5'h00, 10'h000, 1'b1, "R1 near key");
        do_read(13'h100, 32'h0000_0000, "R1 unchanged");
        do_read(13'h080, 32'h0000_0100, "R1 lock unchanged");
        // R2 key byte stripped on the top channel
        do_write(13'h324, 32'h5AAB_CDEF, 5'h00, 10'h200, 1'b0, "R9 channel");
        do_read(13'h324, 32'h00AB_CDEF, "R2 stripped");
        // R5 misaligned read of a mapped word
        do_read(13'h325, 32'h0000_0000, "R5 misaligned read");

        // R7 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_read(13'h100, 32'h0000_0100, "R7 control after reset");
        do_read(13'h200, 32'h0001_0000, "R7 analog after reset");
        do_read(13'h30C, 32'h0000_0100, "R7 channel after reset");
        do_read(13'h080, 32'h0000_0000, "R7 lock after reset");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule